// File: doc/BRIEF.md
# Parasite-to-Host Byte Pair Transfer FIFO

This block carries bulk data from a parasite processor to a host processor through a tiny FIFO that holds at most two bytes. The parasite pushes bytes with a write strobe and polls a status byte; the host pulls bytes with a read strobe and polls its own status byte. A mode input picks single-byte operation, where the FIFO behaves like one latch, or paired operation, where both bytes move as a unit.

In paired mode the handshake flags are hysteretic. They move only when the FIFO becomes completely full or completely empty, never on a single byte. A parasite that polls its not-full flag therefore cannot refill the FIFO after the host has taken only the first byte of a pair. The same drain-to-empty event sets an interrupt flag in the parasite status byte. It also raises an interrupt request when the enable input is high. A host DMA request follows the data-available flag. A write that would exceed the capacity is dropped and latches a sticky overflow indication.

Top module: `r3_fifo`

## Requirements
- R1: After reset the FIFO is empty, parasite status reads 8'h40 (bit 6 not-full set, bit 7 interrupt flag clear), host status reads 8'h00, and the interrupt request, DMA request and overflow outputs are low.
- R2: In single-byte mode (wide_mode=0) one accepted write sets host status bit 7 (data available) and clears parasite status bit 6. The read that empties the FIFO reverses both.
- R3: In paired mode (wide_mode=1) the first write into an empty FIFO leaves host bit 7 clear and parasite bit 6 set. The second write sets host bit 7 and clears parasite bit 6.
- R4: In paired mode, reading the first of two bytes leaves host bit 7 set and parasite bit 6 clear, and the second byte moves to host_rdata. The second read clears host bit 7 and sets parasite bit 6.
- R5: Bytes are delivered in write order, and host_rdata always shows the oldest stored byte, which a read strobe consumes.
- R6: The read that empties the FIFO clears host bit 7 and sets parasite bits 7 and 6 in the same cycle. Parasite bit 7 clears when the FIFO next reaches its capacity.
- R7: par_nmi rises only on a read that empties the FIFO while nmi_en is high, and stays high until the FIFO reaches capacity. Raising nmi_en later does not raise it.
- R8: host_drq is high exactly when host status bit 7 is set.
- R9: A write while the FIFO holds its capacity (1 in single-byte mode, 2 in paired mode) is discarded, leaves the stored bytes unchanged, and sets ovf_sticky, which stays set until reset.
- R10: A read strobe while the FIFO is empty returns the last delivered byte on host_rdata and changes no flag or stored state.
- R11: When both strobes are active in one cycle, the read consumes the oldest byte. The write is accepted only if the count before that cycle was below capacity, and the accepted byte goes behind any byte that remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_mode | input | 1 | 1 selects paired (two-byte) operation, 0 single-byte |
| nmi_en | input | 1 | Enables the parasite interrupt request on drain |
| par_wr | input | 1 | Parasite write strobe, one cycle per byte |
| par_wdata | input | DATA_W | Parasite write data |
| par_status | output | 8 | Parasite status: bit 7 interrupt flag, bit 6 not-full |
| par_nmi | output | 1 | Interrupt request to the parasite |
| host_rd | input | 1 | Host read strobe, one cycle per byte |
| host_rdata | output | DATA_W | Oldest stored byte |
| host_status | output | 8 | Host status: bit 7 data available |
| host_drq | output | 1 | DMA request to the host |
| ovf_sticky | output | 1 | Set by any discarded write |

## Verification
The hardest state to reach is a paired-mode FIFO that is only partly drained, with the flags still showing "full" while one byte remains. The stimulus brings it about with a read and a write in the same cycle on a full FIFO, so the write is refused. A second simultaneous read and write then replaces the remaining byte without either flag moving. The interrupt gating is reached by draining once with the enable low, raising the enable afterwards and observing no request, then draining again with it high.

// File: rtl/r3_fifo_pkg.sv
package r3_fifo_pkg;

   localparam int STAT_W      = 8;
   localparam int PAR_NMI_BIT = 7;
   localparam int PAR_NF_BIT  = 6;
   localparam int HOST_DA_BIT = 7;

   typedef struct packed {
      logic avail;
      logic not_full;
      logic nmi_flag;
      logic nmi_pend;
      logic ovf;
   } r3_flags_t;

   function automatic logic [STAT_W-1:0] par_stat_pack(input r3_flags_t f);
      logic [STAT_W-1:0] s;
      s = '0;
      s[PAR_NMI_BIT] = f.nmi_flag;
      s[PAR_NF_BIT]  = f.not_full;
      return s;
   endfunction

   function automatic logic [STAT_W-1:0] host_stat_pack(input r3_flags_t f);
      logic [STAT_W-1:0] s;
      s = '0;
      s[HOST_DA_BIT] = f.avail;
      return s;
   endfunction

endpackage

// File: rtl/r3_store.sv
module r3_store #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 2,
   parameter int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_go,
   input  logic              rd_go,
   input  logic [DATA_W-1:0] din,
   input  logic [CNT_W-1:0]  cnt_nxt,
   output logic [CNT_W-1:0]  cnt_q,
   output logic [DATA_W-1:0] head
);

   logic [DEPTH-1:0][DATA_W-1:0] slot_q;
   logic [DEPTH-1:0][DATA_W-1:0] slot_d;
   logic [CNT_W-1:0]             wpos;

   // after a simultaneous read the free position moves down by one
   assign wpos = rd_go ? (cnt_q - CNT_W'(1)) : cnt_q;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic load;
      assign load = wr_go && (wpos == CNT_W'(i));
      if (i == DEPTH - 1) begin : g_tail
         assign slot_d[i] = load ? din : slot_q[i];
      end else begin : g_body
         logic shift;
         assign shift = rd_go && (CNT_W'(i + 1) < cnt_q);
         assign slot_d[i] = load  ? din :
                            shift ? slot_q[i+1] : slot_q[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_q <= '0;
         cnt_q  <= '0;
      end else begin
         slot_q <= slot_d;
         cnt_q  <= cnt_nxt;
      end
   end

   assign head = slot_q[0];

endmodule

// File: rtl/r3_flags.sv
module r3_flags
   import r3_fifo_pkg::*;
#(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_nxt,
   input  logic [CNT_W-1:0] cap,
   input  logic             rd_go,
   input  logic             drop,
   input  logic             nmi_en,
   output r3_flags_t        flg
);

   logic full_evt;
   logic empty_evt;
   logic drain_evt;

   assign full_evt  = (cnt_nxt == cap);
   assign empty_evt = (cnt_nxt == '0);
   assign drain_evt = rd_go && empty_evt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flg.avail    <= 1'b0;
         flg.not_full <= 1'b1;
         flg.nmi_flag <= 1'b0;
         flg.nmi_pend <= 1'b0;
         flg.ovf      <= 1'b0;
      end else begin
         // flags move only at the full and empty boundaries
         if (full_evt) begin
            flg.avail    <= 1'b1;
            flg.not_full <= 1'b0;
            flg.nmi_flag <= 1'b0;
            flg.nmi_pend <= 1'b0;
         end else if (empty_evt) begin
            flg.avail    <= 1'b0;
            flg.not_full <= 1'b1;
            if (drain_evt) begin
               flg.nmi_flag <= 1'b1;
               if (nmi_en) flg.nmi_pend <= 1'b1;
            end
         end
         if (drop) flg.ovf <= 1'b1;
      end
   end

endmodule

// File: rtl/r3_fifo.sv
module r3_fifo
   import r3_fifo_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wide_mode,
   input  logic              nmi_en,
   input  logic              par_wr,
   input  logic [DATA_W-1:0] par_wdata,
   output logic [7:0]        par_status,
   output logic              par_nmi,
   input  logic              host_rd,
   output logic [DATA_W-1:0] host_rdata,
   output logic [7:0]        host_status,
   output logic              host_drq,
   output logic              ovf_sticky
);

   localparam int CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("r3_fifo: DEPTH must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("r3_fifo: DATA_W must be positive");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nxt;
   logic [CNT_W-1:0] cap;
   logic             wr_go;
   logic             rd_go;
   logic             drop;
   r3_flags_t        flg;

   assign cap     = wide_mode ? CNT_W'(DEPTH) : CNT_W'(1);
   assign wr_go   = par_wr && (cnt_q < cap);
   assign drop    = par_wr && !wr_go;
   assign rd_go   = host_rd && (cnt_q != '0);
   assign cnt_nxt = cnt_q + CNT_W'(wr_go) - CNT_W'(rd_go);

   r3_store #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH),
      .CNT_W  (CNT_W)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_go   (wr_go),
      .rd_go   (rd_go),
      .din     (par_wdata),
      .cnt_nxt (cnt_nxt),
      .cnt_q   (cnt_q),
      .head    (host_rdata)
   );

   r3_flags #(
      .CNT_W (CNT_W)
   ) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .cnt_nxt (cnt_nxt),
      .cap     (cap),
      .rd_go   (rd_go),
      .drop    (drop),
      .nmi_en  (nmi_en),
      .flg     (flg)
   );

   assign par_status  = par_stat_pack(flg);
   assign host_status = host_stat_pack(flg);
   assign par_nmi     = flg.nmi_pend;
   assign host_drq    = flg.avail;
   assign ovf_sticky  = flg.ovf;

endmodule

// File: rtl/r3_fifo_chk.sv
module r3_fifo_chk #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 2,
   parameter int CNT_W  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wide_mode,
   input logic              nmi_en,
   input logic              par_wr,
   input logic              host_rd,
   input logic [CNT_W-1:0]  cnt_q,
   input logic [7:0]        par_status,
   input logic [7:0]        host_status,
   input logic              par_nmi,
   input logic              host_drq,
   input logic              ovf_sticky,
   input logic [DATA_W-1:0] host_rdata
);

   logic [CNT_W-1:0] cap_c;
   assign cap_c = wide_mode ? CNT_W'(DEPTH) : CNT_W'(1);

   p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(DEPTH));

   p_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (par_wr && !host_rd && cnt_q >= cap_c) |=> (ovf_sticky && $stable(cnt_q)));

   p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_sticky |=> ovf_sticky);

   p_avail_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(host_status[7]) |-> (cnt_q == $past(cap_c)));

   p_nf_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(par_status[6]) |-> (cnt_q == '0));

   p_flags_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_status[7] && par_status[6]));

   p_nmi_implies_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      par_nmi |-> par_status[7]);

   p_nmi_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(par_nmi) |-> ($past(host_rd) && $past(nmi_en) && cnt_q == '0));

   p_drq_r8: assert property (@(posedge clk) disable iff (!rst_n)
      host_drq == host_status[7]);

   p_empty_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && !par_wr && cnt_q == '0) |=> ($stable(host_rdata) && cnt_q == '0));

endmodule

bind r3_fifo r3_fifo_chk #(
   .DATA_W (DATA_W),
   .DEPTH  (DEPTH),
   .CNT_W  (CNT_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wide_mode   (wide_mode),
   .nmi_en      (nmi_en),
   .par_wr      (par_wr),
   .host_rd     (host_rd),
   .cnt_q       (cnt_q),
   .par_status  (par_status),
   .host_status (host_status),
   .par_nmi     (par_nmi),
   .host_drq    (host_drq),
   .ovf_sticky  (ovf_sticky),
   .host_rdata  (host_rdata)
);

// File: tb/r3_fifo_test.sv
module r3_fifo_test;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       wide_mode;
   logic       nmi_en;
   logic       par_wr;
   logic [7:0] par_wdata;
   logic [7:0] par_status;
   logic       par_nmi;
   logic       host_rd;
   logic [7:0] host_rdata;
   logic [7:0] host_status;
   logic       host_drq;
   logic       ovf_sticky;

   int         total = 0;
   int         bad   = 0;
   int         mcnt  = 0;
   logic [7:0] exp_q[$];
   logic [7:0] last_out = 8'h00;
   bit         finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   r3_fifo uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .wide_mode   (wide_mode),
      .nmi_en      (nmi_en),
      .par_wr      (par_wr),
      .par_wdata   (par_wdata),
      .par_status  (par_status),
      .par_nmi     (par_nmi),
      .host_rd     (host_rd),
      .host_rdata  (host_rdata),
      .host_status (host_status),
      .host_drq    (host_drq),
      .ovf_sticky  (ovf_sticky)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic flags(input string req, input logic [7:0] ps, input logic [7:0] hs,
                        input logic nmi);
      chk({req, " par_status"}, {24'h0, par_status}, {24'h0, ps});
      chk({req, " host_status"}, {24'h0, host_status}, {24'h0, hs});
      chk({req, " par_nmi"}, {31'h0, par_nmi}, {31'h0, nmi});
      chk("R8 drq follows avail", {31'h0, host_drq}, {31'h0, hs[7]});
   endtask

   // driver: one strobe cycle, expected bytes go to the scoreboard queue
   task automatic op(input logic wr, input logic [7:0] d, input logic rd);
      int capm;
      int nc;
      capm = wide_mode ? 2 : 1;
      @(negedge clk);
      par_wr    = wr;
      par_wdata = d;
      host_rd   = rd;
      if (wr && mcnt < capm) exp_q.push_back(d);
      @(negedge clk);
      par_wr  = 1'b0;
      host_rd = 1'b0;
      nc = mcnt;
      if (rd && mcnt > 0) nc--;
      if (wr && mcnt < capm) nc++;
      mcnt = nc;
   endtask

   // monitor: compares each read against the scoreboard
   initial begin
      forever begin
         @(negedge clk);
         #(CLK_PERIOD/4);
         if (host_rd === 1'b1) begin
            if (mcnt > 0) begin
               logic [7:0] e;
               e = exp_q.pop_front();
               chk("R5 data order", {24'h0, host_rdata}, {24'h0, e});
               last_out = e;
            end else begin
               chk("R10 empty read data", {24'h0, host_rdata}, {24'h0, last_out});
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; wide_mode = 1'b0; nmi_en = 1'b0;
      par_wr = 1'b0; par_wdata = 8'h00; host_rd = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      flags("R1 reset", 8'h40, 8'h00, 1'b0);
      chk("R1 reset ovf", {31'h0, ovf_sticky}, 32'h0);

      // single-byte mode
      op(1'b1, 8'hA1, 1'b0);
      flags("R2 one-byte full", 8'h00, 8'h80, 1'b0);
      op(1'b1, 8'hA2, 1'b0);
      chk("R9 drop sets ovf", {31'h0, ovf_sticky}, 32'h1);
      chk("R9 drop keeps data", {24'h0, host_rdata}, 32'hA1);
      op(1'b0, 8'h00, 1'b1);
      flags("R6 drain one-byte", 8'hC0, 8'h00, 1'b0);
      nmi_en = 1'b1;
      repeat (2) @(negedge clk);
      chk("R7 late enable no nmi", {31'h0, par_nmi}, 32'h0);
      op(1'b0, 8'h00, 1'b1);
      flags("R10 empty read state", 8'hC0, 8'h00, 1'b0);

      // paired mode
      wide_mode = 1'b1;
      op(1'b1, 8'hB1, 1'b0);
      flags("R3 first of pair", 8'hC0, 8'h00, 1'b0);
      op(1'b1, 8'hB2, 1'b0);
      flags("R3 pair full", 8'h00, 8'h80, 1'b0);
      op(1'b0, 8'h00, 1'b1);
      flags("R4 half drained", 8'h00, 8'h80, 1'b0);
      chk("R4 second byte shifted", {24'h0, host_rdata}, 32'hB2);
      op(1'b0, 8'h00, 1'b1);
      flags("R7 drain raises nmi", 8'hC0, 8'h00, 1'b1);
      op(1'b1, 8'hC1, 1'b0);
      flags("R7 nmi held", 8'hC0, 8'h00, 1'b1);
      op(1'b1, 8'hC2, 1'b0);
      flags("R6 fill clears nmi flag", 8'h00, 8'h80, 1'b0);
      op(1'b1, 8'hC3, 1'b0);
      chk("R9 pair drop keeps head", {24'h0, host_rdata}, 32'hC1);
      chk("R9 ovf still set", {31'h0, ovf_sticky}, 32'h1);

      // simultaneous strobes
      op(1'b1, 8'hD1, 1'b1);
      flags("R11 full read+write", 8'h00, 8'h80, 1'b0);
      chk("R11 refused write", {24'h0, host_rdata}, 32'hC2);
      op(1'b1, 8'hD2, 1'b1);
      flags("R11 swap keeps flags", 8'h00, 8'h80, 1'b0);
      chk("R11 accepted byte", {24'h0, host_rdata}, 32'hD2);
      op(1'b0, 8'h00, 1'b1);
      flags("R4 pair drained", 8'hC0, 8'h00, 1'b1);

      wide_mode = 1'b0;
      op(1'b1, 8'hE1, 1'b1);
      flags("R11 empty read with write", 8'h00, 8'h80, 1'b0);
      op(1'b0, 8'h00, 1'b1);
      flags("R2 one-byte drain", 8'hC0, 8'h00, 1'b1);
      chk("R5 queue empty", exp_q.size(), 32'h0);

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule